// File: doc/BRIEF.md
# Trigger Summary Max and Sum

This block condenses one event's worth of per-channel trigger values into a single compact word. Each event presents 32 eight-bit trigger values at once, together with a valid strobe and the 8-bit bunch-crossing identifier of that event. The block finds the largest value and the channel that holds it. It adds all 32 values and limits the total to 8 bits. It then packs these three results and the crossing identifier into one 29-bit word.

The datapath is a three-stage pipeline. The first stage reduces groups of channels to a local winner and a local partial sum. The second stage combines the groups. The third stage clamps the sum and packs the word. A new event may be presented on every clock cycle. Downstream logic takes the packed word whenever the output valid flag is high.

Top module: `trig_summary_max_sum`

## Requirements
- R1: The max field equals the largest of the 32 channel values, where channel i is carried on `in_chan[8*i+7 : 8*i]`.
- R2: The index field gives the channel number (0 to 31) of the largest value. When several channels share the largest value, the lowest channel number is reported.
- R3: When the true total of all 32 channels is 255 or less, the sum field equals that total exactly.
- R4: When the true total exceeds 255, the sum field reads 255.
- R5: The summary word is packed as follows: bits [28:21] hold the max, bits [20:16] the index, bits [15:8] the sum, and bits [7:0] the crossing identifier presented with the event.
- R6: `out_valid` rises on the third rising clock edge after the edge that samples `in_valid` high, and an event accepted on every cycle yields one result on every cycle. An edge that samples `in_valid` low produces no valid result three edges later.
- R7: A synchronous active-high reset drives `out_valid` low and `out_summary` to zero, and discards events already inside the pipeline.
- R8: While no new result is due, `out_summary` keeps the last result it delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks an event on the inputs this cycle |
| in_bxid | input | 8 | Bunch-crossing identifier of the event |
| in_chan | input | 256 | 32 trigger values, channel i at bits 8*i+7 : 8*i |
| out_valid | output | 1 | Marks a new summary on `out_summary` |
| out_summary | output | 29 | Packed max, index, clamped sum and crossing identifier |

## Verification
Every result (the max, its index, the clamped sum and the echoed crossing identifier) appears on the port three rising edges after the edge that captures the event. No field arrives earlier than the others. The bench streams its vector table back to back and drives each vector at a falling edge. It compares the output at the falling edge three cycles later against the vector issued three iterations before. It also confirms that `out_valid` stays low during the first three cycles of the stream. The directed tests for a single isolated event, for holding the last result and for a reset during a flush count edges the same way. Each test samples at the falling edge after exactly the expected number of rising edges.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int NUM_CH    = 32;
    localparam int CH_W      = 8;
    localparam int BX_W      = 8;
    localparam int SUM_OUT_W = 8;

    localparam int IDX_W      = $clog2(NUM_CH);
    localparam int SUM_FULL_W = CH_W + IDX_W;
    localparam int SUMMARY_W  = CH_W + IDX_W + SUM_OUT_W + BX_W;
    localparam int SUM_LIMIT  = (1 << SUM_OUT_W) - 1;

    typedef struct packed {
        logic [CH_W-1:0]  value;
        logic [IDX_W-1:0] idx;
    } cand_t;

    typedef struct packed {
        logic [CH_W-1:0]      max_val;
        logic [IDX_W-1:0]     max_idx;
        logic [SUM_OUT_W-1:0] sum_sat;
        logic [BX_W-1:0]      bxid;
    } summary_t;

    function automatic logic [SUM_OUT_W-1:0] clamp_sum(input logic [SUM_FULL_W-1:0] s);
        if (s > SUM_FULL_W'(SUM_LIMIT))
            return '1;
        else
            return s[SUM_OUT_W-1:0];
    endfunction

endpackage

// File: rtl/tsm_argmax.sv
module tsm_argmax
    import tsm_pkg::*;
#(
    parameter int N = 4
) (
    input  cand_t cands [N],
    output cand_t best
);
    // Candidates arrive in ascending channel order; only a strictly larger
    // value displaces the current best, so ties keep the lower channel.
    always_comb begin
        best = cands[0];
        for (int i = 1; i < N; i++) begin
            if (cands[i].value > best.value)
                best = cands[i];
        end
    end
endmodule

// File: rtl/tsm_sum.sv
module tsm_sum #(
    parameter int N     = 4,
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + $clog2(N)
) (
    input  logic [IN_W-1:0]  vals [N],
    output logic [OUT_W-1:0] total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++)
            total = total + OUT_W'(vals[i]);
    end
endmodule

// File: rtl/trig_summary_max_sum.sv
module trig_summary_max_sum
    import tsm_pkg::*;
#(
    parameter int GROUP = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [BX_W-1:0]        in_bxid,
    input  logic [NUM_CH*CH_W-1:0] in_chan,
    output logic                   out_valid,
    output logic [SUMMARY_W-1:0]   out_summary
);
    localparam int NGRP   = NUM_CH / GROUP;
    localparam int GSUM_W = CH_W + $clog2(GROUP);
    localparam int S2_W   = GSUM_W + $clog2(NGRP);

    // ---------------- stage 1: per-group winner and partial sum ----------
    cand_t              grp_best [NGRP];
    logic [GSUM_W-1:0]  grp_sum  [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cand_t           gc [GROUP];
        logic [CH_W-1:0] gv [GROUP];
        for (genvar k = 0; k < GROUP; k++) begin : g_ch
            assign gv[k]       = in_chan[(g*GROUP+k)*CH_W +: CH_W];
            assign gc[k].value = gv[k];
            assign gc[k].idx   = IDX_W'(g*GROUP + k);
        end
        tsm_argmax #(.N(GROUP)) u_max (.cands(gc), .best(grp_best[g]));
        tsm_sum #(.N(GROUP), .IN_W(CH_W), .OUT_W(GSUM_W)) u_sum (
            .vals(gv), .total(grp_sum[g])
        );
    end

    cand_t             grp_s1  [NGRP];
    logic [GSUM_W-1:0] gsum_s1 [NGRP];
    logic [BX_W-1:0]   bx_s1;
    logic              v_s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_s1  <= 1'b0;
            bx_s1 <= '0;
            for (int g = 0; g < NGRP; g++) begin
                grp_s1[g]  <= '0;
                gsum_s1[g] <= '0;
            end
        end else begin
            v_s1  <= in_valid;
            bx_s1 <= in_bxid;
            for (int g = 0; g < NGRP; g++) begin
                grp_s1[g]  <= grp_best[g];
                gsum_s1[g] <= grp_sum[g];
            end
        end
    end

    // ---------------- stage 2: combine groups ----------------------------
    cand_t           win_c;
    logic [S2_W-1:0] sum_c;

    tsm_argmax #(.N(NGRP)) u_max_fin (.cands(grp_s1), .best(win_c));
    tsm_sum #(.N(NGRP), .IN_W(GSUM_W), .OUT_W(S2_W)) u_sum_fin (
        .vals(gsum_s1), .total(sum_c)
    );

    cand_t           win_s2;
    logic [S2_W-1:0] sum_s2;
    logic [BX_W-1:0] bx_s2;
    logic            v_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_s2   <= 1'b0;
            win_s2 <= '0;
            sum_s2 <= '0;
            bx_s2  <= '0;
        end else begin
            v_s2   <= v_s1;
            win_s2 <= win_c;
            sum_s2 <= sum_c;
            bx_s2  <= bx_s1;
        end
    end

    // ---------------- stage 3: clamp, pack, hold ------------------------
    summary_t pack_c;
    always_comb begin
        pack_c.max_val = win_s2.value;
        pack_c.max_idx = win_s2.idx;
        pack_c.sum_sat = clamp_sum(SUM_FULL_W'(sum_s2));
        pack_c.bxid    = bx_s2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_summary <= '0;
        end else begin
            out_valid <= v_s2;
            if (v_s2)
                out_summary <= pack_c;
        end
    end

    // ---------------- assertions ----------------------------------------
    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        // R1: the overall winner is never smaller than any group winner
        a_r1_max_dominates: assert property (@(posedge clk) disable iff (rst)
            v_s1 |=> (win_s2.value >= $past(grp_s1[g].value)));
        // R2: on equal values the reported channel is the lower one
        a_r2_tie_lowest: assert property (@(posedge clk) disable iff (rst)
            (v_s1 && (win_c.value == grp_s1[g].value)) |=>
                (win_s2.idx <= $past(grp_s1[g].idx)));
    end

    a_r3_sum_exact: assert property (@(posedge clk) disable iff (rst)
        (v_s2 && (sum_s2 <= S2_W'(SUM_LIMIT))) |=>
            (out_summary[BX_W +: SUM_OUT_W] == $past(sum_s2[SUM_OUT_W-1:0])));

    a_r4_sum_clamp: assert property (@(posedge clk) disable iff (rst)
        (v_s2 && (sum_s2 > S2_W'(SUM_LIMIT))) |=>
            (out_summary[BX_W +: SUM_OUT_W] == SUM_OUT_W'(SUM_LIMIT)));

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##2 out_valid);

    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_summary == '0)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !v_s2 |=> $stable(out_summary));

endmodule

// File: tb/trig_summary_max_sum_tb.sv
module trig_summary_max_sum_tb;
    import tsm_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   in_valid;
    logic [BX_W-1:0]        in_bxid;
    logic [NUM_CH*CH_W-1:0] in_chan;
    logic                   out_valid;
    logic [SUMMARY_W-1:0]   out_summary;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    trig_summary_max_sum u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bxid(in_bxid),
        .in_chan(in_chan), .out_valid(out_valid), .out_summary(out_summary)
    );

    // fill value for all channels, then ch p <= v, then ch q <= w
    typedef struct packed {
        logic [7:0] fill;
        logic [4:0] p;
        logic [7:0] v;
        logic [4:0] q;
        logic [7:0] w;
        logic [7:0] bx;
        logic [7:0] e_max;
        logic [4:0] e_idx;
        logic [7:0] e_sum;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   5'd5,  8'd9,   5'd5,  8'd9,   8'h11, 8'd9,   5'd5,  8'd9},
        '{8'd0,   5'd31, 8'd255, 5'd0,  8'd0,   8'h22, 8'd255, 5'd31, 8'd255},
        '{8'd0,   5'd3,  8'd100, 5'd20, 8'd100, 8'h33, 8'd100, 5'd3,  8'd200},
        '{8'd1,   5'd0,  8'd200, 5'd31, 8'd1,   8'h44, 8'd200, 5'd0,  8'd231},
        '{8'd8,   5'd7,  8'd8,   5'd7,  8'd8,   8'h55, 8'd8,   5'd0,  8'd255},
        '{8'd0,   5'd0,  8'd0,   5'd0,  8'd0,   8'hAA, 8'd0,   5'd0,  8'd0},
        '{8'd255, 5'd0,  8'd255, 5'd0,  8'd255, 8'hFF, 8'd255, 5'd0,  8'd255},
        '{8'd7,   5'd16, 8'd50,  5'd17, 8'd49,  8'h01, 8'd50,  5'd16, 8'd255},
        '{8'd0,   5'd10, 8'd30,  5'd12, 8'd31,  8'h7E, 8'd31,  5'd12, 8'd61}
    };

    task automatic drive_vec(input vec_t t);
        for (int c = 0; c < NUM_CH; c++) in_chan[c*CH_W +: CH_W] = t.fill;
        in_chan[int'(t.p)*CH_W +: CH_W] = t.v;
        in_chan[int'(t.q)*CH_W +: CH_W] = t.w;
        in_bxid  = t.bx;
        in_valid = 1'b1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [SUMMARY_W-1:0] expect_word(input vec_t t);
        return {t.e_max, t.e_idx, t.e_sum, t.bx};  // R5 packing
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_bxid = '0; in_chan = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 reset valid", 64'(out_valid), 64'd0);
        check("R7 reset summary", 64'(out_summary), 64'd0);
        rst = 1'b0;

        // Table walk, back to back (R1 R2 R3 R4 R5 R6)
        for (int i = 0; i <= NV + 2; i++) begin
            @(negedge clk);
            if (i < 3) check("R6 no early valid", 64'(out_valid), 64'd0);
            else begin
                check("R6 valid per cycle", 64'(out_valid), 64'd1);
                check("R1 R2 R3 R4 R5 summary", 64'(out_summary), 64'(expect_word(VECS[i-3])));
            end
            if (i < NV) drive_vec(VECS[i]);
            else in_valid = 1'b0;
        end

        // R8: idle cycles keep the last result
        repeat (3) begin
            @(negedge clk);
            check("R8 valid low when idle", 64'(out_valid), 64'd0);
            check("R8 summary held", 64'(out_summary), 64'(expect_word(VECS[NV-1])));
        end

        // R6: single isolated event yields exactly one pulse after three edges
        drive_vec(VECS[2]);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); check("R6 single not yet (2 edges)", 64'(out_valid), 64'd0);
        @(negedge clk); check("R6 single due (3 edges)", 64'(out_valid), 64'd1);
        check("R2 tie lowest single", 64'(out_summary[20:16]), 64'd3);
        @(negedge clk); check("R6 single pulse ends", 64'(out_valid), 64'd0);
        check("R8 held after single", 64'(out_summary), 64'(expect_word(VECS[2])));

        // R7: reset discards events in flight
        drive_vec(VECS[1]);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R7 flush summary cleared", 64'(out_summary), 64'd0);
        repeat (3) begin
            @(negedge clk);
            check("R7 flushed event absent", 64'(out_valid), 64'd0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule